// File: doc/BRIEF.md
# Row-Organized Wide Register File

This block holds sixty-four 256-bit vector registers for a wide datapath. Storage is sixteen rows of 1024 bits, and each row carries four consecutive registers side by side. Because of this layout, a whole aligned 1024-bit memory line can fill a group of four registers in one write. The same layout lets a read pick one row and then narrow it down with a lane and element multiplexer.

There are three ports. The read port returns a full register, or a single 8, 16, 32 or 64-bit element of it. The element is right-aligned and zero-extended, and the result appears two clock edges after the request. The register write port stores either a whole 256-bit vector or a scalar of the requested width; a scalar write clears the rest of the register. The line port writes four registers from one line. It accepts the line only when the byte address of the line sits on a 128-byte boundary; otherwise it flags an error and leaves storage untouched.

Top module: `wide_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, all registers are cleared to zero and `rd_valid` and `ml_err` are driven low.
- R2: Register n lives in row n[5:2] at 256-bit lane n[1:0]. A read of register n returns the last value committed to register n, independent of the other three registers of its row.
- R3: A read request sampled at edge k gives `rd_valid` high with its data after edge k+1. `rd_valid` is low after any edge k+1 whose edge k carried no request.
- R4: `rd_size` codes are 0=8, 1=16, 2=32, 3=64 bits, and 4..7 mean the full 256 bits. The element number is the low bits of `rd_idx` that fit the count (5, 4, 3 or 2 bits; none for 256). Element e of width w is register bits [e*w +: w]. It is returned in `rd_data` bits [w-1:0], with all higher bits zero.
- R5: A register write with `wr_scalar`=0 stores all 256 bits of `wr_data`.
- R6: A register write with `wr_scalar`=1 stores the low 8, 16, 32 or 64 bits of `wr_data` (`wr_size` codes 0..3) into the low element and writes zeros to every higher bit of the register.
- R7: A line write with `ml_addr`[6:0]=0 writes `ml_line`[l*256 +: 256] into register {`ml_reg`[5:2], l} for l=0..3. The value of `ml_reg`[1:0] has no effect.
- R8: A line write with `ml_addr`[6:0] not zero raises `ml_err` for exactly the following cycle and changes no register.
- R9: A read sampled in the same edge as a write to the same register returns the value from before that write.
- R10: If the register write port and an accepted line write hit the same register in one edge, the register write port's value is kept. The other three registers of the group take their line data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_reg | input | 6 | Register to read |
| rd_size | input | 3 | Element size code for the read |
| rd_idx | input | 5 | Element number within the register |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 6 | Register to write |
| wr_scalar | input | 1 | 1: scalar write of wr_size, 0: full 256-bit write |
| wr_size | input | 2 | Scalar size code |
| wr_data | input | 256 | Write data |
| ml_en | input | 1 | Line write strobe |
| ml_reg | input | 6 | Any register of the target group |
| ml_addr | input | 32 | Byte address of the memory line |
| ml_line | input | 1024 | Line data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 256 | Read data, right-aligned and zero-extended |
| ml_err | output | 1 | Misaligned line write seen on the previous edge |

## Verification
The bench targets reads that coincide with a write to the same register. A design that forwards the new data, or that captures the row one stage late, returns the new value instead of the old one. Line writes are issued with nonzero `ml_reg`[1:0] and with misaligned addresses. A wrong lane decode scrambles the group, and a missing alignment gate corrupts four registers that must stay intact. Scalar writes go into registers that already hold full-width data, which exposes a failure to zero-fill. Narrow reads use element numbers with stray upper bits, which exposes unmasked index bits or an element that is not zero-extended.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int REG_W      = 256;
    localparam int LANES      = 4;
    localparam int ROW_W      = REG_W * LANES;
    localparam int NUM_REGS   = 64;
    localparam int NUM_ROWS   = NUM_REGS / LANES;
    localparam int REG_IDX_W  = $clog2(NUM_REGS);
    localparam int LANE_W     = $clog2(LANES);
    localparam int ROW_IDX_W  = $clog2(NUM_ROWS);
    localparam int LINE_OFS_W = $clog2(ROW_W / 8);
    localparam int ELEM_IDX_W = $clog2(REG_W / 8);

    typedef enum logic [2:0] {
        SZ8 = 3'd0, SZ16 = 3'd1, SZ32 = 3'd2, SZ64 = 3'd3, SZFULL = 3'd4
    } esize_e;

    typedef logic [REG_W-1:0] vreg_t;
    typedef logic [ROW_W-1:0] vrow_t;

    typedef struct packed {
        logic                 en;
        logic [ROW_IDX_W-1:0] row;
        logic [LANE_W-1:0]    lane;
        vreg_t                val;
    } regwr_t;

    function automatic esize_e decode_size(input logic [2:0] code);
        return (code > 3'd3) ? SZFULL : esize_e'(code);
    endfunction

    // zero-extended low element of the given size
    function automatic vreg_t low_elem(input vreg_t v, input esize_e sz);
        case (sz)
            SZ8:     return REG_W'(v[7:0]);
            SZ16:    return REG_W'(v[15:0]);
            SZ32:    return REG_W'(v[31:0]);
            SZ64:    return REG_W'(v[63:0]);
            default: return v;
        endcase
    endfunction

    function automatic vreg_t pick_elem(input vreg_t v, input esize_e sz,
                                        input logic [ELEM_IDX_W-1:0] idx);
        case (sz)
            SZ8:     return REG_W'(v[int'(idx)*8 +: 8]);
            SZ16:    return REG_W'(v[int'(idx[3:0])*16 +: 16]);
            SZ32:    return REG_W'(v[int'(idx[2:0])*32 +: 32]);
            SZ64:    return REG_W'(v[int'(idx[1:0])*64 +: 64]);
            default: return v;
        endcase
    endfunction

    // true when no bit above the element width is set
    function automatic logic fits_size(input vreg_t v, input esize_e sz);
        return low_elem(v, sz) == v;
    endfunction
endpackage

// File: rtl/wrf_line_gate.sv
module wrf_line_gate
    import wrf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ml_en,
    input  logic [ADDR_W-1:0] ml_addr,
    output logic              ml_go,
    output logic              ml_err
);
    logic misaligned;
    assign misaligned = |ml_addr[LINE_OFS_W-1:0];
    assign ml_go      = ml_en && !misaligned;

    always_ff @(posedge clk) begin
        if (rst) ml_err <= 1'b0;
        else     ml_err <= ml_en && misaligned;
    end

    a_r8_err_follows_bad_addr: assert property (@(posedge clk) disable iff (rst)
        (ml_en && ml_addr[LINE_OFS_W-1:0] != '0) |=> ml_err);
    a_r8_err_needs_request: assert property (@(posedge clk) disable iff (rst)
        !ml_en |=> !ml_err);
endmodule

// File: rtl/wrf_row_store.sv
module wrf_row_store
    import wrf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  regwr_t               rw,
    input  logic                 scalar_chk,
    input  esize_e               scalar_sz,
    input  logic                 ml_go,
    input  logic [ROW_IDX_W-1:0] ml_row,
    input  vrow_t                ml_line,
    input  logic [ROW_IDX_W-1:0] rd_row,
    output vrow_t                rd_row_data
);
    vrow_t rows [NUM_ROWS];
    vrow_t nxt  [NUM_ROWS];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        always_comb begin
            nxt[g] = rows[g];
            if (ml_go && ml_row == ROW_IDX_W'(g))
                nxt[g] = ml_line;
            // register port applied last so it wins on overlap (R10)
            if (rw.en && rw.row == ROW_IDX_W'(g))
                nxt[g][int'(rw.lane)*REG_W +: REG_W] = rw.val;
        end
        always_ff @(posedge clk) begin
            if (rst) rows[g] <= '0;
            else     rows[g] <= nxt[g];
        end
    end

    assign rd_row_data = rows[rd_row];

    // checker state: last scalar write target
    logic                 chk_v;
    logic [ROW_IDX_W-1:0] chk_row;
    logic [LANE_W-1:0]    chk_lane;
    esize_e               chk_sz;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v    <= 1'b0;
            chk_row  <= '0;
            chk_lane <= '0;
            chk_sz   <= SZ8;
        end else begin
            chk_v    <= rw.en && scalar_chk;
            chk_row  <= rw.row;
            chk_lane <= rw.lane;
            chk_sz   <= scalar_sz;
        end
    end

    a_r6_scalar_zero_fill: assert property (@(posedge clk) disable iff (rst)
        chk_v |-> fits_size(rows[chk_row][int'(chk_lane)*REG_W +: REG_W], chk_sz));
endmodule

// File: rtl/wrf_read_pipe.sv
module wrf_read_pipe
    import wrf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [LANE_W-1:0]     rd_lane,
    input  logic [2:0]            rd_size,
    input  logic [ELEM_IDX_W-1:0] rd_idx,
    input  vrow_t                 row_in,
    output logic                  rd_valid,
    output vreg_t                 rd_data
);
    // stage 1: row capture
    logic                  v1;
    vrow_t                 row_q;
    logic [LANE_W-1:0]     lane_q;
    esize_e                sz_q;
    logic [ELEM_IDX_W-1:0] idx_q;
    // stage 2 size kept for the output check
    esize_e                sz2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1     <= 1'b0;
            row_q  <= '0;
            lane_q <= '0;
            sz_q   <= SZ8;
            idx_q  <= '0;
        end else begin
            v1 <= rd_en;
            if (rd_en) begin
                row_q  <= row_in;
                lane_q <= rd_lane;
                sz_q   <= decode_size(rd_size);
                idx_q  <= rd_idx;
            end
        end
    end

    vreg_t lane_val;
    assign lane_val = row_q[int'(lane_q)*REG_W +: REG_W];

    // stage 2: lane and element select
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            sz2      <= SZ8;
        end else begin
            rd_valid <= v1;
            sz2      <= sz_q;
            if (v1) rd_data <= pick_elem(lane_val, sz_q, idx_q);
        end
    end

    a_r3_stage_one: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> v1);
    a_r3_stage_two: assert property (@(posedge clk) disable iff (rst)
        v1 |=> rd_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !v1 |=> !rd_valid);
    a_r4_zero_extended: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> fits_size(rd_data, sz2));
endmodule

// File: rtl/wide_regfile.sv
module wide_regfile
    import wrf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [REG_IDX_W-1:0]  rd_reg,
    input  logic [2:0]            rd_size,
    input  logic [ELEM_IDX_W-1:0] rd_idx,
    input  logic                  wr_en,
    input  logic [REG_IDX_W-1:0]  wr_reg,
    input  logic                  wr_scalar,
    input  logic [1:0]            wr_size,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  ml_en,
    input  logic [REG_IDX_W-1:0]  ml_reg,
    input  logic [ADDR_W-1:0]     ml_addr,
    input  logic [ROW_W-1:0]      ml_line,
    output logic                  rd_valid,
    output logic [REG_W-1:0]      rd_data,
    output logic                  ml_err
);
    esize_e wsz;
    regwr_t rw;
    logic   ml_go;
    vrow_t  row_data;

    assign wsz     = esize_e'({1'b0, wr_size});
    assign rw.en   = wr_en;
    assign rw.row  = wr_reg[REG_IDX_W-1:LANE_W];
    assign rw.lane = wr_reg[LANE_W-1:0];
    assign rw.val  = wr_scalar ? low_elem(wr_data, wsz) : wr_data;

    wrf_line_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk(clk), .rst(rst), .ml_en(ml_en), .ml_addr(ml_addr),
        .ml_go(ml_go), .ml_err(ml_err)
    );

    wrf_row_store u_store (
        .clk(clk), .rst(rst), .rw(rw),
        .scalar_chk(wr_scalar), .scalar_sz(wsz),
        .ml_go(ml_go), .ml_row(ml_reg[REG_IDX_W-1:LANE_W]), .ml_line(ml_line),
        .rd_row(rd_reg[REG_IDX_W-1:LANE_W]), .rd_row_data(row_data)
    );

    wrf_read_pipe u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en),
        .rd_lane(rd_reg[LANE_W-1:0]), .rd_size(rd_size), .rd_idx(rd_idx),
        .row_in(row_data), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!rd_valid && !ml_err));
endmodule

// File: tb/wide_regfile_tb.sv
module wide_regfile_tb_top;
    logic          clk = 1'b0;
    logic          rst;
    logic          rd_en, wr_en, wr_scalar, ml_en;
    logic [5:0]    rd_reg, wr_reg, ml_reg;
    logic [2:0]    rd_size;
    logic [4:0]    rd_idx;
    logic [1:0]    wr_size;
    logic [255:0]  wr_data;
    logic [31:0]   ml_addr;
    logic [1023:0] ml_line;
    logic          rd_valid, ml_err;
    logic [255:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    logic [255:0] model [64];

    always #2 clk = ~clk;

    wide_regfile dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_reg(rd_reg), .rd_size(rd_size),
        .rd_idx(rd_idx), .wr_en(wr_en), .wr_reg(wr_reg), .wr_scalar(wr_scalar),
        .wr_size(wr_size), .wr_data(wr_data), .ml_en(ml_en), .ml_reg(ml_reg),
        .ml_addr(ml_addr), .ml_line(ml_line), .rd_valid(rd_valid),
        .rd_data(rd_data), .ml_err(ml_err)
    );

    function automatic logic [255:0] rand256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // expected element: width from code, index taken modulo element count
    function automatic logic [255:0] exp_elem(logic [255:0] v, logic [2:0] code, logic [4:0] idx);
        int w, n, e;
        logic [255:0] r;
        w = (code > 3) ? 256 : (8 << code);
        n = 256 / w;
        e = int'(idx) % n;
        r = '0;
        for (int b = 0; b < w; b++) r[b] = v[e*w + b];
        return r;
    endfunction

    function automatic logic [255:0] exp_wr(logic [255:0] d, logic sc, logic [1:0] sz);
        logic [255:0] r;
        int w;
        if (!sc) return d;
        w = 8 << sz;
        r = '0;
        for (int b = 0; b < w; b++) r[b] = d[b];
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = 0; wr_en = 0; ml_en = 0;
    endtask

    task automatic do_wr(logic [5:0] r, logic sc, logic [1:0] sz, logic [255:0] d);
        wr_en = 1; wr_reg = r; wr_scalar = sc; wr_size = sz; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
        model[r] = exp_wr(d, sc, sz);
    endtask

    task automatic do_ml(logic [5:0] r, logic [31:0] a, logic [1023:0] line, string req);
        logic bad;
        bad = (a[6:0] != 0);
        ml_en = 1; ml_reg = r; ml_addr = a; ml_line = line;
        @(posedge clk); @(negedge clk);
        ml_en = 0;
        check(req, 256'(ml_err), 256'(bad));
        if (!bad)
            for (int l = 0; l < 4; l++) model[{r[5:2], 2'(l)}] = line[l*256 +: 256];
    endtask

    task automatic do_rd(logic [5:0] r, logic [2:0] sz, logic [4:0] idx, string req);
        rd_en = 1; rd_reg = r; rd_size = sz; rd_idx = idx;
        @(posedge clk); @(negedge clk);
        rd_en = 0;
        @(posedge clk); @(negedge clk);
        check({req, " valid"}, 256'(rd_valid), 256'(1));
        check(req, rd_data, exp_elem(model[r], sz, idx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] oldv, nv;
        logic [1023:0] ln;
        void'($urandom(32'h5EED_0042));
        idle();
        rd_reg = 0; rd_size = 0; rd_idx = 0; wr_reg = 0; wr_scalar = 0;
        wr_size = 0; wr_data = '0; ml_reg = 0; ml_addr = 0; ml_line = '0;
        for (int i = 0; i < 64; i++) model[i] = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 rd_valid", 256'(rd_valid), 256'(0));
        check("R1 ml_err", 256'(ml_err), 256'(0));
        do_rd(6'd0, 3'd4, 0, "R1 reg0 zero");
        do_rd(6'd63, 3'd4, 0, "R1 reg63 zero");
        // R3 valid drops after the single read
        @(posedge clk); @(negedge clk);
        check("R3 valid low", 256'(rd_valid), 256'(0));

        // R5 full writes to neighbouring lanes, R2 mapping
        for (int i = 20; i < 24; i++) do_wr(6'(i), 0, 0, rand256());
        for (int i = 20; i < 24; i++) do_rd(6'(i), 3'd4, 0, "R2 R5 lane isolation");

        // R6 scalar writes over full data
        do_wr(6'd21, 0, 0, '1);
        do_wr(6'd21, 1, 2'd0, rand256());
        do_rd(6'd21, 3'd4, 0, "R6 scalar8 zero fill");
        do_wr(6'd22, 1, 2'd3, '1);
        do_rd(6'd22, 3'd4, 0, "R6 scalar64 zero fill");

        // R4 element select with stray idx bits and odd size codes
        do_wr(6'd5, 0, 0, rand256());
        do_rd(6'd5, 3'd0, 5'd31, "R4 byte 31");
        do_rd(6'd5, 3'd1, 5'd31, "R4 half idx masked");
        do_rd(6'd5, 3'd2, 5'd13, "R4 word idx masked");
        do_rd(6'd5, 3'd3, 5'd30, "R4 dword idx masked");
        do_rd(6'd5, 3'd7, 5'd9, "R4 code7 full");

        // R7 line write, ml_reg low bits ignored
        for (int i = 0; i < 32; i++) ln[i*32 +: 32] = $urandom;
        do_ml(6'd43, 32'h0000_1380, ln, "R7 aligned no err");
        for (int i = 40; i < 44; i++) do_rd(6'(i), 3'd4, 0, "R7 group lanes");

        // R8 misaligned: no write, error pulse
        do_ml(6'd40, 32'h0000_1381, ~ln, "R8 err raised");
        @(posedge clk); @(negedge clk);
        check("R8 err one cycle", 256'(ml_err), 256'(0));
        for (int i = 40; i < 44; i++) do_rd(6'(i), 3'd4, 0, "R8 group untouched");
        do_ml(6'd40, 32'h0000_13C0, ~ln, "R8 offset 64 err");

        // R9 read-before-write on same register
        oldv = model[41]; nv = rand256();
        rd_en = 1; rd_reg = 6'd41; rd_size = 3'd4; rd_idx = 0;
        wr_en = 1; wr_reg = 6'd41; wr_scalar = 0; wr_data = nv;
        @(posedge clk); @(negedge clk);
        idle();
        @(posedge clk); @(negedge clk);
        check("R9 old data", rd_data, oldv);
        model[41] = nv;
        do_rd(6'd41, 3'd4, 0, "R9 new data after");

        // R10 both ports hit the same register
        for (int i = 0; i < 32; i++) ln[i*32 +: 32] = $urandom;
        nv = rand256();
        wr_en = 1; wr_reg = 6'd10; wr_scalar = 0; wr_data = nv;
        ml_en = 1; ml_reg = 6'd8; ml_addr = 32'h8000_0000; ml_line = ln;
        @(posedge clk); @(negedge clk);
        idle();
        for (int l = 0; l < 4; l++) model[8 + l] = ln[l*256 +: 256];
        model[10] = nv;
        for (int i = 8; i < 12; i++) do_rd(6'(i), 3'd4, 0, "R10 port priority");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            if (op < 2)
                do_wr(6'($urandom), 1'($urandom), 2'($urandom), rand256());
            else if (op == 2) begin
                for (int i = 0; i < 32; i++) ln[i*32 +: 32] = $urandom;
                do_ml(6'($urandom), ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFFF_FF80),
                      ln, "R7 R8 random line");
            end
            do_rd(6'($urandom), 3'($urandom), 5'($urandom), "R2 R4 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule